// File: doc/BRIEF.md
# Prescaled Free-Running Capture/Compare Timer

This block is a 16-bit time base for capture and compare work. A counter that software cannot touch counts up from zero after reset. Its rate comes from a prescaler whose two-bit select picks a divide of 1, 4, 8 or 16 of the system clock. At the top of its range the counter wraps to zero and raises an overflow flag.

Eight channels use the counter. Three channels capture the count when an edge arrives on a pin. Four channels compare the count with a stored value and act on a pin when the two are equal. One more channel takes either role, chosen by a mode input.

Each channel and the overflow have a sticky flag, an enable bit and an interrupt request line of their own. Software loads the compare values, clears flags and sets enables through a small write port. All compare registers come out of reset holding 0xFFFF.

Top module: `capcmp_timer`

## Requirements
- R1: While reset is held, the count, every flag, the overflow flag, every capture latch, every compare pin and every interrupt request are zero.
- R2: `pre_sel` selects the tick rate: 00 gives one tick per clock, 01 one tick per 4 clocks, 10 one per 8 and 11 one per 16. Over any 64 clocks with the select held, the count advances by 64 divided by that ratio.
- R3: The count advances by exactly one on each tick and never changes by any other amount.
- R4: No write alters the count at any address. Address map: 0 to 3 are the compare registers of compare channels 0 to 3, 4 is the compare register of the dual channel, 14 is flag clear, 15 is interrupt enable, and all other addresses are ignored.
- R5: When a tick finds the count at 0xFFFF, the count becomes 0x0000 and `ovf_flag` is set.
- R6: Capture slot k (slots 0 to 2 are the capture channels, slot 3 is the dual channel) uses `edge_sel[2k+1:2k]`, where bit 2k enables rising edges and bit 2k+1 enables falling edges. On an enabled edge, the slot latches the count value from before that clock's increment into `cap_q[16k+15:16k]` and sets its flag. Capture channel k uses `flags[k]`.
- R7: An edge of a kind that the slot has not enabled changes neither its latch nor its flag.
- R8: Compare channel j sets `flags[3+j]` on the tick in which the count equals its compare register.
- R9: On that match, the pin of compare slot j (`oc_pin[j]`, with slot 4 being the dual channel) follows `oc_act[2j+1:2j]`: 01 toggles, 10 clears, 11 sets and 00 leaves it unchanged.
- R10: The dual channel uses `flags[7]`. With `dual_is_cmp` = 1 it compares against address 4 and drives `oc_pin[4]`, and its capture pin is ignored. With `dual_is_cmp` = 0 it captures from `cap_pin[3]` into slot 3, and its compare has no effect.
- R11: A write to address 14 clears each flag whose bit is 1 and leaves flags whose bit is 0 unchanged. Bits 0 to 7 select `flags`, and bit 8 selects `ovf_flag`. An event in the same cycle as a clear wins.
- R12: `irq[i]` is high while source i's flag and its enable bit (address 15, same bit layout as R11) are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pre_sel | input | 2 | Prescale select |
| cap_pin | input | 4 | Capture pins, slot 3 is the dual channel |
| edge_sel | input | 8 | Per capture slot: rising-enable and falling-enable bits |
| dual_is_cmp | input | 1 | Dual channel role, 1 = compare |
| oc_act | input | 10 | Per compare slot: pin action on match |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| count | output | 16 | Free-running count |
| cap_q | output | 64 | Capture latches, 16 bits per slot |
| flags | output | 8 | Channel flags |
| ovf_flag | output | 1 | Counter overflow flag |
| oc_pin | output | 5 | Compare pins |
| irq | output | 9 | Interrupt requests, bit 8 is overflow |

## Verification
The bench measures the count across 64-clock windows under each prescale select. A prescaler that decoded the wrong phase or the wrong ratio would advance the count by the wrong amount. It writes every address while tracking the count, so a decode that reached the counter would break the expected step. It waits out a full wrap from 0xFFFF and catches an overflow flag that is set early, set late or not set at all.

On the capture side it drives edges of the kind each slot has not enabled. It also holds the dual channel in each role while exercising the other role. A design that captured on the wrong edge, or that let the inactive role set the shared flag, would be caught. Compare checks sample the flag one clock before and one clock after the match. They cover every pin action, including a second toggle, and a partial flag clear that must leave the other flags standing.

// File: rtl/capcmp_timer.sv
module capcmp_timer #(
  parameter int CW   = 16,
  parameter int N_IC = 3,
  parameter int N_OC = 4,
  parameter int AW   = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 pre_sel,
  input  logic [N_IC:0]              cap_pin,
  input  logic [2*(N_IC+1)-1:0]      edge_sel,
  input  logic                       dual_is_cmp,
  input  logic [2*(N_OC+1)-1:0]      oc_act,
  input  logic                       wr_en,
  input  logic [AW-1:0]              wr_addr,
  input  logic [CW-1:0]              wr_data,
  output logic [CW-1:0]              count,
  output logic [(N_IC+1)*CW-1:0]     cap_q,
  output logic [N_IC+N_OC:0]         flags,
  output logic                       ovf_flag,
  output logic [N_OC:0]              oc_pin,
  output logic [N_IC+N_OC+1:0]       irq
);
  localparam int NCH  = N_IC + N_OC + 1;
  localparam int NCAP = N_IC + 1;
  localparam int NCMP = N_OC + 1;
  localparam int DUAL = NCH - 1;
  localparam logic [AW-1:0] A_CLR = AW'((1 << AW) - 2);
  localparam logic [AW-1:0] A_IEN = AW'((1 << AW) - 1);

  logic [3:0]      pdiv, pmask;
  logic            tick, wrap;
  logic [NCH:0]    ien, clr_bits;
  logic [NCAP-1:0] cap_prev, cap_hit;
  logic [NCMP-1:0] cmp_hit;
  logic [NCH-1:0]  ev;
  logic [CW-1:0]   cap_r [NCAP];
  logic [CW-1:0]   cmp_r [NCMP];

  always_comb begin
    case (pre_sel)
      2'd0:    pmask = 4'h0;
      2'd1:    pmask = 4'h3;
      2'd2:    pmask = 4'h7;
      default: pmask = 4'hF;
    endcase
  end

  assign tick     = (pdiv & pmask) == pmask;
  assign wrap     = tick && (count == {CW{1'b1}});
  assign clr_bits = (wr_en && wr_addr == A_CLR) ? wr_data[NCH:0] : '0;
  assign irq      = {ovf_flag, flags} & ien;

  always_comb begin
    for (int k = 0; k < NCAP; k++)
      cap_hit[k] = (k < N_IC || !dual_is_cmp) &&
                   ((edge_sel[2*k]   &&  cap_pin[k] && !cap_prev[k]) ||
                    (edge_sel[2*k+1] && !cap_pin[k] &&  cap_prev[k]));
    for (int j = 0; j < NCMP; j++)
      cmp_hit[j] = tick && (count == cmp_r[j]) && (j < N_OC || dual_is_cmp);
    ev = '0;
    for (int k = 0; k < N_IC; k++) ev[k] = cap_hit[k];
    for (int j = 0; j < N_OC; j++) ev[N_IC+j] = cmp_hit[j];
    ev[DUAL] = cap_hit[N_IC] | cmp_hit[N_OC];
  end

  for (genvar k = 0; k < NCAP; k++) begin : g_capq
    assign cap_q[k*CW +: CW] = cap_r[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pdiv     <= '0;
      count    <= '0;
      ovf_flag <= 1'b0;
      flags    <= '0;
      ien      <= '0;
      cap_prev <= '0;
      oc_pin   <= '0;
      for (int k = 0; k < NCAP; k++) cap_r[k] <= '0;
      for (int j = 0; j < NCMP; j++) cmp_r[j] <= '1;
    end else begin
      pdiv     <= pdiv + 4'd1;
      cap_prev <= cap_pin;
      if (tick) count <= count + CW'(1);
      for (int k = 0; k < NCAP; k++)
        if (cap_hit[k]) cap_r[k] <= count;
      for (int j = 0; j < NCMP; j++) begin
        if (wr_en && wr_addr == AW'(j)) cmp_r[j] <= wr_data;
        if (cmp_hit[j])
          case (oc_act[2*j +: 2])
            2'b01:   oc_pin[j] <= ~oc_pin[j];
            2'b10:   oc_pin[j] <= 1'b0;
            2'b11:   oc_pin[j] <= 1'b1;
            default: ;
          endcase
      end
      if (wr_en && wr_addr == A_IEN) ien <= wr_data[NCH:0];
      flags    <= (flags & ~clr_bits[NCH-1:0]) | ev;
      ovf_flag <= (ovf_flag & ~clr_bits[NCH]) | wrap;
    end
  end
endmodule

// File: rtl/capcmp_timer_chk.sv
module capcmp_timer_chk #(
  parameter int CW   = 16,
  parameter int N_IC = 3,
  parameter int NCH  = 8,
  parameter int NCAP = 4,
  parameter int NCMP = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [CW-1:0]        count,
  input logic                 ovf_flag,
  input logic [NCH-1:0]       flags,
  input logic [NCAP*CW-1:0]   cap_q,
  input logic [NCMP-1:0]      oc_pin
);
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    count != $past(count) |-> count == $past(count) + CW'(1)); // R3

  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> (count == '0 && $past(count) == {CW{1'b1}})); // R5

  for (genvar k = 0; k < NCAP; k++) begin : g_cap
    localparam int FB = (k < N_IC) ? k : NCH - 1;
    AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cap_q[k*CW +: CW]) |-> flags[FB]); // R6
  end

  for (genvar j = 0; j < NCMP; j++) begin : g_pin
    localparam int FB = (j < NCMP - 1) ? N_IC + j : NCH - 1;
    AST_PIN_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(oc_pin[j]) |-> flags[FB]); // R9
  end
endmodule

bind capcmp_timer capcmp_timer_chk #(
  .CW(CW), .N_IC(N_IC), .NCH(NCH), .NCAP(NCAP), .NCMP(NCMP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .count(count), .ovf_flag(ovf_flag),
  .flags(flags), .cap_q(cap_q), .oc_pin(oc_pin)
);

// File: tb/sim_capcmp_timer.sv
module sim_capcmp_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  pre_sel;
  logic [3:0]  cap_pin;
  logic [7:0]  edge_sel;
  logic        dual_is_cmp;
  logic [9:0]  oc_act;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [15:0] wr_data;
  logic [15:0] count;
  logic [63:0] cap_q;
  logic [7:0]  flags;
  logic        ovf_flag;
  logic [4:0]  oc_pin;
  logic [8:0]  irq;

  int errors = 0;
  int checks = 0;

  capcmp_timer u0 (
    .clk(clk), .rst_n(rst_n), .pre_sel(pre_sel), .cap_pin(cap_pin),
    .edge_sel(edge_sel), .dual_is_cmp(dual_is_cmp), .oc_act(oc_act),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .count(count),
    .cap_q(cap_q), .flags(flags), .ovf_flag(ovf_flag), .oc_pin(oc_pin), .irq(irq)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic clr_all();
    wr(4'd14, 16'h01FF);
  endtask

  task automatic wait_cnt(input logic [15:0] v);
    int n = 0;
    while (count != v && n < 70000) begin
      step();
      n++;
    end
    if (count != v) chk(1'b0, "wait", count, v);
  endtask

  function automatic logic [15:0] slot(input int k);
    return cap_q[k*16 +: 16];
  endfunction

  task automatic t_reset();
    chk(count == 0, "R1 count", count, 0);
    chk(flags == 0 && ovf_flag == 0, "R1 flags", {ovf_flag, flags}, 0);
    chk(cap_q == 0, "R1 capture", cap_q, 0);
    chk(oc_pin == 0 && irq == 0, "R1 pins/irq", {oc_pin, irq}, 0);
  endtask

  task automatic t_count();
    logic [15:0] c = count;
    repeat (10) step();
    chk(count == c + 16'd10, "R3 step", count, c + 16'd10);
  endtask

  task automatic t_presc();
    for (int s = 0; s < 4; s++) begin
      logic [15:0] c0;
      int dv;
      dv = (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 16;
      pre_sel = 2'(s);
      c0 = count;
      repeat (64) step();
      chk(count - c0 == 16'(64 / dv), "R2 prescale", count - c0, 64 / dv);
    end
    pre_sel = 2'd0;
  endtask

  task automatic t_nowrite();
    logic [15:0] c = count;
    for (int a = 0; a < 16; a++) begin
      wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'h0000;
      step();
    end
    wr_en = 1'b0;
    chk(count == c + 16'd16, "R4 writes leave count", count, c + 16'd16);
  endtask

  task automatic t_cmp();
    logic [15:0] t;
    oc_act = 10'b00_00_11_10_01;
    clr_all();
    wr(4'd15, 16'h0008);
    t = count + 16'd40;
    for (int j = 0; j < 4; j++) wr(4'(j), t);
    wait_cnt(t);
    chk(flags[6:3] == 0, "R8 before match", flags[6:3], 0);
    chk(irq[3] == 0, "R12 irq before", irq[3], 0);
    step();
    chk(flags[6:3] == 4'hF, "R8 match flags", flags[6:3], 4'hF);
    chk(oc_pin[3:0] == 4'b0101, "R9 pin actions", oc_pin[3:0], 4'b0101);
    chk(irq[3] == 1, "R12 irq on flag", irq[3], 1);
    wr(4'd14, 16'h0008);
    chk(flags[6:3] == 4'b1110, "R11 partial clear", flags[6:3], 4'b1110);
    chk(irq[3] == 0, "R12 irq follows clear", irq[3], 0);
    wr(4'd14, 16'h0000);
    chk(flags[6:3] == 4'b1110, "R11 zero bits keep", flags[6:3], 4'b1110);
    clr_all();
    t = count + 16'd20;
    wr(4'd0, t);
    wait_cnt(t);
    step();
    chk(oc_pin[0] == 0, "R9 second toggle", oc_pin[0], 0);
    oc_act = '0;
  endtask

  task automatic t_cap();
    logic [15:0] c;
    logic [15:0] old0;
    edge_sel = 8'b00_10_11_01;
    clr_all();
    c = count; cap_pin[0] = 1; cap_pin[2] = 1;
    step();
    chk(slot(0) == c && flags[0], "R6 rising capture", {flags[0], slot(0)}, {1'b1, c});
    chk(slot(2) == 0 && !flags[2], "R7 rise ignored", {flags[2], slot(2)}, 0);
    old0 = slot(0);
    clr_all();
    c = count; cap_pin[0] = 0; cap_pin[2] = 0;
    step();
    chk(slot(2) == c && flags[2], "R6 falling capture", {flags[2], slot(2)}, {1'b1, c});
    chk(slot(0) == old0 && !flags[0], "R7 fall ignored", {flags[0], slot(0)}, {1'b0, old0});
    clr_all();
    c = count; cap_pin[1] = 1;
    step();
    chk(slot(1) == c && flags[1], "R6 both rise", {flags[1], slot(1)}, {1'b1, c});
    clr_all();
    c = count; cap_pin[1] = 0;
    step();
    chk(slot(1) == c && flags[1], "R6 both fall", {flags[1], slot(1)}, {1'b1, c});
  endtask

  task automatic t_dual();
    logic [15:0] t, c, cv;
    dual_is_cmp = 0; edge_sel[7:6] = 2'b01; oc_act[9:8] = 2'b01;
    clr_all();
    t = count + 16'd20;
    wr(4'd4, t);
    wait_cnt(t);
    step();
    chk(!flags[7] && !oc_pin[4], "R10 compare off in capture role", {flags[7], oc_pin[4]}, 0);
    c = count; cap_pin[3] = 1;
    step();
    chk(slot(3) == c && flags[7], "R10 dual capture", {flags[7], slot(3)}, {1'b1, c});
    cap_pin[3] = 0; dual_is_cmp = 1;
    clr_all();
    cv = slot(3);
    t = count + 16'd20;
    wr(4'd4, t);
    cap_pin[3] = 1;
    step(); step();
    chk(!flags[7] && slot(3) == cv, "R10 capture off in compare role", {flags[7], slot(3)}, {1'b0, cv});
    wait_cnt(t);
    step();
    chk(flags[7] && oc_pin[4], "R10 dual compare", {flags[7], oc_pin[4]}, 2'b11);
  endtask

  task automatic t_ovf();
    wr(4'd15, 16'h0100);
    clr_all();
    wait_cnt(16'hFFFF);
    chk(!ovf_flag && !irq[8], "R5 no flag before wrap", {ovf_flag, irq[8]}, 0);
    step();
    chk(count == 0, "R5 wrap to zero", count, 0);
    chk(ovf_flag && irq[8], "R5 R12 overflow flag/irq", {ovf_flag, irq[8]}, 2'b11);
    clr_all();
    chk(!ovf_flag && !irq[8], "R11 overflow clear", {ovf_flag, irq[8]}, 0);
  endtask

  initial begin
    rst_n = 0; pre_sel = 0; cap_pin = 0; edge_sel = 0; dual_is_cmp = 0;
    oc_act = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
    repeat (3) step();
    t_reset();
    rst_n = 1;
    t_count();
    t_presc();
    t_nowrite();
    t_cmp();
    t_cap();
    t_dual();
    t_ovf();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule